// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This unit performs the two long-running arithmetic operations of a small accumulator processor. It is either an unsigned byte-by-byte multiply or an unsigned divide of a 16-bit value by a byte. The processor hands over its accumulator (A), index-low (X) and index-high (H) register values together with a one-cycle start pulse and an operation select. Some cycles later the unit returns a one-cycle done pulse. Along with it come the new register values, the carry, zero and half-carry results, and masks that say which registers and which flags the processor should write.

Both operations run iteratively. The multiplier does one shift-and-add step per multiplier bit. The divider does one restoring shift-subtract step per dividend bit. A divide by zero, or a divide whose quotient does not fit a byte, does not update A or H. It only sets carry. While an operation runs, the unit is busy and ignores further start pulses.

The reset input clears the unit at once. The unit leaves reset on the second rising clock edge after the reset input goes high.

Top module: `muldiv_seq`

## Requirements
- R1: A multiply (op_div_i = 0) returns the product A×X with the low byte on a_o and the high byte on x_o. h_o returns the original H. wr_mask_o is 3'b011 (bit0 = A, bit1 = X, bit2 = H).
- R2: A multiply returns c_o = 0 and hc_o = 0. flag_mask_o is 3'b101 (bit0 = C, bit1 = Z, bit2 = H), so Z is not written.
- R3: A divide (op_div_i = 1) with X ≠ 0 and a quotient of at most 0xFF returns the quotient of the dividend {H,A} by X on a_o and the remainder on h_o. x_o returns the original X. wr_mask_o is 3'b101.
- R4: A successful divide returns c_o = 0 and z_o = 1 exactly when the quotient is zero. flag_mask_o is 3'b011.
- R5: A divide with X = 0 returns c_o = 1, wr_mask_o = 3'b000 and flag_mask_o = 3'b001. a_o, x_o and h_o return the original values.
- R6: A divide whose quotient exceeds 0xFF behaves as in R5: c_o = 1, no register written, and the original values are returned.
- R7: done_o is first seen high 17 rising edges after the edge that accepts a divide start, and 9 rising edges after the edge that accepts a multiply start.
- R8: done_o lasts exactly one cycle. busy_o is high from the accepting edge until done_o rises, and is low while done_o is high. A start pulse while busy_o is high is ignored and changes neither the timing nor the results of the running operation.
- R9: wr_mask_o and flag_mask_o are all zero whenever done_o is low.
- R10: While rst_n is low, done_o, busy_o, wr_mask_o and flag_mask_o are zero, and a reset in the middle of an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request, taken when busy_o is low |
| op_div_i | input | 1 | 1 = divide, 0 = multiply |
| a_i | input | DW | Accumulator value |
| x_i | input | DW | Index-low value (multiplier or divisor) |
| h_i | input | DW | Index-high value (dividend high byte) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| a_o | output | DW | New accumulator value |
| x_o | output | DW | New index-low value |
| h_o | output | DW | New index-high value |
| c_o | output | 1 | Carry result |
| z_o | output | 1 | Zero result |
| hc_o | output | 1 | Half-carry result |
| wr_mask_o | output | 3 | Register write mask: bit0 A, bit1 X, bit2 H |
| flag_mask_o | output | 3 | Flag write mask: bit0 C, bit1 Z, bit2 H |

## Verification
Every result is due together with done_o: 17 rising edges after the accepting edge of a divide, and 9 after the accepting edge of a multiply. The bench drives start on a falling edge and then counts falling edges until done_o is seen. It checks that count against the latency in R7, and it compares values and masks only in that cycle. In the next cycle it checks that done_o has dropped and the masks are zero. The ignored-start test pulses start five cycles into a divide. It then confirms that the divide result still arrives at edge 17 and that no second done follows for twenty cycles.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_t;

  // register write mask positions
  localparam int WM_A = 0;
  localparam int WM_X = 1;
  localparam int WM_H = 2;
  // flag write mask positions
  localparam int FM_C = 0;
  localparam int FM_Z = 1;
  localparam int FM_H = 2;
endpackage

// File: rtl/muldiv_rst_sync.sv
module muldiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int DIV_STEPS = 16,
  parameter int MUL_STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic op_div_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic op_div_o,
  output logic busy_o
);
  localparam int MAXS = (DIV_STEPS > MUL_STEPS) ? DIV_STEPS : MUL_STEPS;
  localparam int CW   = $clog2(MAXS + 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_STEPS - 1);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_STEPS - 1);

  md_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          op_q, op_d;
  logic          last_step;

  assign last_step = (cnt_q == (op_q ? DIV_LAST : MUL_LAST));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          op_d    = op_div_i;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
    end
  end

  assign load_o   = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign finish_o = (state_q == ST_FIN);
  assign busy_o   = (state_q != ST_IDLE);
  assign op_div_o = op_q;
endmodule

// File: rtl/muldiv_div_dp.sv
module muldiv_div_dp #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [2*DW-1:0] dividend_i,
  input  logic [DW-1:0]   divisor_i,
  output logic [2*DW-1:0] quot_o,
  output logic [DW-1:0]   rem_o
);
  logic [2*DW-1:0] quo_q, quo_d;
  logic [DW-1:0]   rem_q, rem_d;
  logic [DW-1:0]   dvs_q;
  logic [DW:0]     trial, diff;
  logic            fits;

  // one restoring shift-subtract step
  always_comb begin
    trial = {rem_q, quo_q[2*DW-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
    rem_d = fits ? diff[DW-1:0] : trial[DW-1:0];
    quo_d = {quo_q[2*DW-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      quo_q <= dividend_i;
      rem_q <= '0;
      dvs_q <= divisor_i;
    end else if (step_i) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/muldiv_mul_dp.sv
module muldiv_mul_dp #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [DW-1:0]   mcand_i,
  input  logic [DW-1:0]   mplier_i,
  output logic [2*DW-1:0] prod_o
);
  logic [2*DW-1:0] prod_q, prod_d;
  logic [DW-1:0]   mcand_q;
  logic [DW:0]     sum;

  // one shift-and-add step, multiplier bits consumed from the low end
  always_comb begin
    sum    = {1'b0, prod_q[2*DW-1:DW]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_d = {sum, prod_q[DW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      prod_q  <= {{DW{1'b0}}, mplier_i};
      mcand_q <= mcand_i;
    end else if (step_i) begin
      prod_q  <= prod_d;
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_div_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] h_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] h_o,
  output logic          c_o,
  output logic          z_o,
  output logic          hc_o,
  output logic [2:0]    wr_mask_o,
  output logic [2:0]    flag_mask_o
);
  localparam int DIV_STEPS = 2 * DW;
  localparam int MUL_STEPS = DW;

  logic rst_n_i;
  logic load, step, finish, op_div;
  logic [2*DW-1:0] quot, prod;
  logic [DW-1:0]   rem;

  // latched operands
  logic [DW-1:0] opa_q, opx_q, oph_q;

  // result registers
  logic [DW-1:0] ra_q, rx_q, rh_q, ra_d, rx_d, rh_d;
  logic          rc_q, rz_q, rhc_q, rc_d, rz_d, rhc_d;
  logic [2:0]    wm_q, fm_q, wm_d, fm_d;
  logic          done_q;
  logic          div_bad;

  muldiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  muldiv_ctrl #(
    .DIV_STEPS (DIV_STEPS),
    .MUL_STEPS (MUL_STEPS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start_i  (start_i),
    .op_div_i (op_div_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .op_div_o (op_div),
    .busy_o   (busy_o)
  );

  muldiv_div_dp #(.DW(DW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load_i     (load && op_div_i),
    .step_i     (step && op_div),
    .dividend_i ({h_i, a_i}),
    .divisor_i  (x_i),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  muldiv_mul_dp #(.DW(DW)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load_i   (load && !op_div_i),
    .step_i   (step && !op_div),
    .mcand_i  (a_i),
    .mplier_i (x_i),
    .prod_o   (prod)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      opa_q <= '0;
      opx_q <= '0;
      oph_q <= '0;
    end else if (load) begin
      opa_q <= a_i;
      opx_q <= x_i;
      oph_q <= h_i;
    end
  end

  assign div_bad = (opx_q == '0) || (quot[2*DW-1:DW] != '0);

  always_comb begin
    ra_d  = opa_q;
    rx_d  = opx_q;
    rh_d  = oph_q;
    rc_d  = 1'b0;
    rz_d  = 1'b0;
    rhc_d = 1'b0;
    wm_d  = '0;
    fm_d  = '0;
    if (!op_div) begin
      ra_d       = prod[DW-1:0];
      rx_d       = prod[2*DW-1:DW];
      wm_d[WM_A] = 1'b1;
      wm_d[WM_X] = 1'b1;
      fm_d[FM_C] = 1'b1;
      fm_d[FM_H] = 1'b1;
    end else if (div_bad) begin
      rc_d       = 1'b1;
      fm_d[FM_C] = 1'b1;
    end else begin
      ra_d       = quot[DW-1:0];
      rh_d       = rem;
      rz_d       = (quot[DW-1:0] == '0);
      wm_d[WM_A] = 1'b1;
      wm_d[WM_H] = 1'b1;
      fm_d[FM_C] = 1'b1;
      fm_d[FM_Z] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ra_q  <= '0;
      rx_q  <= '0;
      rh_q  <= '0;
      rc_q  <= 1'b0;
      rz_q  <= 1'b0;
      rhc_q <= 1'b0;
      wm_q  <= '0;
      fm_q  <= '0;
    end else if (finish) begin
      ra_q  <= ra_d;
      rx_q  <= rx_d;
      rh_q  <= rh_d;
      rc_q  <= rc_d;
      rz_q  <= rz_d;
      rhc_q <= rhc_d;
      wm_q  <= wm_d;
      fm_q  <= fm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) done_q <= 1'b0;
    else          done_q <= finish;
  end

  assign done_o      = done_q;
  assign a_o         = ra_q;
  assign x_o         = rx_q;
  assign h_o         = rh_q;
  assign c_o         = rc_q;
  assign z_o         = rz_q;
  assign hc_o        = rhc_q;
  assign wr_mask_o   = done_q ? wm_q : 3'b000;
  assign flag_mask_o = done_q ? fm_q : 3'b000;
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          op_div_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] x_i,
  input logic [DW-1:0] h_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] a_o,
  input logic [DW-1:0] x_o,
  input logic [DW-1:0] h_o,
  input logic          c_o,
  input logic          z_o,
  input logic          hc_o,
  input logic [2:0]    wr_mask_o,
  input logic [2:0]    flag_mask_o
);
  localparam logic [7:0] LAT_DIV = 8'(2 * DW + 1);
  localparam logic [7:0] LAT_MUL = 8'(DW + 1);

  logic [7:0] since_q;
  logic       opd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      opd_q   <= 1'b0;
    end else if (start_i && !busy_o) begin
      since_q <= '0;
      opd_q   <= op_div_i;
    end else if (since_q != 8'hFF) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R7 and R8: completion exactly at the latency of the accepted operation
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (since_q == (opd_q ? LAT_DIV : LAT_MUL)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r9_masks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (wr_mask_o == 3'b000 && flag_mask_o == 3'b000));

  a_r2_mul_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !opd_q) |-> (!c_o && !hc_o && flag_mask_o == 3'b101 && wr_mask_o == 3'b011));

  a_r3_div_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && opd_q && !c_o) |-> (wr_mask_o == 3'b101));

  a_r4_div_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && opd_q && !c_o) |-> (z_o == (a_o == '0) && flag_mask_o == 3'b011));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && opd_q && c_o) |-> (wr_mask_o == 3'b000 && flag_mask_o == 3'b001));
endmodule

bind muldiv_seq muldiv_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/muldiv_seq_bench.sv
module muldiv_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       op_div_i = 1'b0;
  logic [7:0] a_i = '0, x_i = '0, h_i = '0;
  logic       busy_o, done_o, c_o, z_o, hc_o;
  logic [7:0] a_o, x_o, h_o;
  logic [2:0] wr_mask_o, flag_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  muldiv_seq #(.DW(8)) u_muldiv_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_div_i(op_div_i),
    .a_i(a_i), .x_i(x_i), .h_i(h_i), .busy_o(busy_o), .done_o(done_o),
    .a_o(a_o), .x_o(x_o), .h_o(h_o), .c_o(c_o), .z_o(z_o), .hc_o(hc_o),
    .wr_mask_o(wr_mask_o), .flag_mask_o(flag_mask_o)
  );

  // {op(1), h(8), a(8), x(8)}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'hFF, 8'hFF},
    {1'b0, 8'h5A, 8'h00, 8'h37},
    {1'b0, 8'h00, 8'h10, 8'h10},
    {1'b1, 8'h00, 8'hFF, 8'h01},
    {1'b1, 8'h01, 8'h00, 8'h01},
    {1'b1, 8'h01, 8'hFE, 8'h02},
    {1'b1, 8'h01, 8'hFF, 8'h02},
    {1'b1, 8'h02, 8'h00, 8'h02},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'hA5, 8'h3C, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h07},
    {1'b1, 8'h12, 8'h34, 8'h56},
    {1'b1, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 8'hFE, 8'hFF, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input bit op, input logic [7:0] h, input logic [7:0] a,
                        input logic [7:0] x);
    op_div_i = op; h_i = h; a_i = a; x_i = x;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // counts rising edges after the accepting one until done is seen
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input bit op, input logic [7:0] h, input logic [7:0] a,
                              input logic [7:0] x, input int lat);
    int dvd, q, r, p;
    logic [7:0] ea, ex, eh;
    bit ec, ez;
    logic [2:0] ewm, efm;
    int elat;
    string rq;
    ea = a; ex = x; eh = h; ec = 1'b0; ez = 1'b0;
    if (!op) begin
      p = int'(a) * int'(x);
      ea = p[7:0]; ex = p[15:8];
      ewm = 3'b011; efm = 3'b101; elat = 9; rq = "R1";
    end else begin
      dvd = int'({h, a});
      elat = 17;
      if (x == 8'h00) begin
        ec = 1'b1; ewm = 3'b000; efm = 3'b001; rq = "R5";
      end else begin
        q = dvd / int'(x); r = dvd % int'(x);
        if (q > 255) begin
          ec = 1'b1; ewm = 3'b000; efm = 3'b001; rq = "R6";
        end else begin
          ea = q[7:0]; eh = r[7:0]; ez = (q == 0);
          ewm = 3'b101; efm = 3'b011; rq = "R3";
        end
      end
    end
    chk(lat == elat, "R7", "latency", lat, elat);
    chk(done_o == 1'b1, "R7", "done", int'(done_o), 1);
    chk(busy_o == 1'b0, "R8", "busy at done", int'(busy_o), 0);
    chk(a_o == ea, rq, "a_o", int'(a_o), int'(ea));
    chk(x_o == ex, rq, "x_o", int'(x_o), int'(ex));
    chk(h_o == eh, rq, "h_o", int'(h_o), int'(eh));
    chk(wr_mask_o == ewm, rq, "wr_mask", int'(wr_mask_o), int'(ewm));
    chk(c_o == ec, op ? (ec ? rq : "R4") : "R2", "c_o", int'(c_o), int'(ec));
    chk(flag_mask_o == efm, op ? (ec ? rq : "R4") : "R2", "flag_mask",
        int'(flag_mask_o), int'(efm));
    if (!op) chk(hc_o == 1'b0, "R2", "hc_o", int'(hc_o), 0);
    else if (!ec) chk(z_o == ez, "R4", "z_o", int'(z_o), int'(ez));
    @(negedge clk);
    chk(done_o == 1'b0, "R8", "done pulse width", int'(done_o), 0);
    chk(wr_mask_o == 3'b000 && flag_mask_o == 3'b000, "R9", "masks after done",
        int'({wr_mask_o, flag_mask_o}), 0);
  endtask

  task automatic run_op(input bit op, input logic [7:0] h, input logic [7:0] a,
                        input logic [7:0] x);
    int lat;
    launch(op, h, a, x);
    chk(busy_o == 1'b1, "R8", "busy after accept", int'(busy_o), 1);
    wait_done(lat);
    check_result(op, h, a, x, lat);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    int lat;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "done/busy in reset",
        int'({done_o, busy_o}), 0);
    chk(wr_mask_o == 3'b000 && flag_mask_o == 3'b000, "R10", "masks in reset",
        int'({wr_mask_o, flag_mask_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_op(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

    lcg = 32'h1234_5679;
    for (int i = 0; i < 150; i++) begin
      logic [7:0] rh, ra, rx;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      ra = lcg[15:8]; rx = lcg[23:16]; rh = lcg[31:24];
      if (lcg[5]) rh = rh % (rx + 8'd1);
      if (lcg[6:4] == 3'd0) rx = 8'h00;
      run_op(lcg[3], rh, ra, rx);
    end

    // R8: start while busy is ignored
    launch(1'b1, 8'h12, 8'h34, 8'h56);
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b1, "R8", "busy mid divide", int'(busy_o), 1);
    op_div_i = 1'b0; a_i = 8'hFF; x_i = 8'hFF; h_i = 8'h00;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 5;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check_result(1'b1, 8'h12, 8'h34, 8'h56, lat);
    begin
      bit extra = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done_o || busy_o) extra = 1'b1;
      end
      chk(!extra, "R8", "ignored start produced work", int'(extra), 0);
    end

    // R10: reset in the middle of an operation
    launch(1'b1, 8'h00, 8'h99, 8'h03);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "done/busy on mid reset",
        int'({done_o, busy_o}), 0);
    chk(wr_mask_o == 3'b000 && flag_mask_o == 3'b000, "R10", "masks on mid reset",
        int'({wr_mask_o, flag_mask_o}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R10", "idle after release",
        int'({done_o, busy_o}), 0);
    run_op(1'b0, 8'h00, 8'h0C, 8'h0D);
    run_op(1'b1, 8'h00, 8'h99, 8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule